// File: doc/BRIEF.md
# Signaling Input Debounce Interrupter

This block watches the signaling lines of two independent channel pairs and tells a host, through one interrupt per pair, when a pair's lines have changed and then settled. Each pair carries ten lines: for each of its two channels, two dedicated input lines and three bidirectional lines. A direction mask marks which bidirectional lines are currently inputs. Lines marked as outputs are left out of change detection and read as 0. All timing is counted in ticks of a single-cycle strobe that arrives every 0.5 ms.

Each pair runs its own state machine. The states are `ST_IDLE` (settled, watching for a change), `ST_SETTLE` (a change was seen and the pair is counting quiet ticks) and `ST_PEND` (the interval has elapsed but the pair's interrupt is still set from an earlier event). The transitions are:
- `change` (IDLE to SETTLE, and PEND to SETTLE).
- `restart` (SETTLE to SETTLE on a new change; the count goes back to zero).
- `fire` (SETTLE to IDLE when the interval completes with the interrupt low; PEND to IDLE once the interrupt has been cleared).
- `defer` (SETTLE to PEND when the interval completes with the interrupt still high).
- `disable` (any state to IDLE while the interval code selects no debouncing).

On `fire` the interrupt rises and the pair's snapshot is loaded. The host clears a pair's interrupt with the read-all-status command, opcode 0x3B, addressed to that pair.

Top module: `sig_debounce_irq`

## Requirements
- R1: Interval codes 0000 and 1110 disable the block. Both interrupts stay 0, and `status_o` shows the live masked inputs of both pairs.
- R2: Codes 0001 to 1101 give an interval of code × 4 ticks (code × 2 ms). The interrupt of a changed pair is still 0 after interval − 1 ticks and is 1 right after the tick that completes the interval.
- R3: Code 1111 gives an interval of one tick (0.5 ms).
- R4: A further change of any enabled line of a pair while it is settling restarts that pair's count from zero.
- R5: A pair's snapshot, shown on its slice of `status_o` while the block is enabled, is loaded only when that pair's interrupt rises, and otherwise holds.
- R6: A read strobe with opcode 0x3B and `rd_pair_i` = p clears interrupt p on the next clock. Any other opcode, or a read of the other pair, leaves the interrupt unchanged.
- R7: Changes on one pair's lines never affect the other pair's interrupt or snapshot.
- R8: Within each pair, bits [1:0] and [6:5] are dedicated inputs and bits [4:2] and [9:7] are bidirectional. A bidirectional bit whose `dir_mask_i` bit is 0 is excluded from change detection and reads as 0. Mask bits at dedicated-input positions are ignored.
- R9: If an interval completes while the pair's interrupt is still 1, the pair defers. The interrupt rises again, with a fresh snapshot, one clock after the clear.
- R10: Without a tick the settle count holds. No amount of clock cycles alone raises an interrupt.
- R11: A completing interval and a clear of the same pair in the same clock leave the interrupt set. The new event is not lost.
- R12: After reset both interrupts and both snapshots are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle 0.5 ms timebase strobe |
| interval_code_i | input | 4 | Debounce interval code |
| dir_mask_i | input | 20 | 1 = bidirectional line is an input; pair p uses bits [10p+9:10p] |
| sig_i | input | 20 | Signaling lines; pair p uses bits [10p+9:10p] |
| rd_strobe_i | input | 1 | Host read command strobe |
| rd_opcode_i | input | 8 | Host read opcode |
| rd_pair_i | input | 1 | Pair addressed by the read |
| irq_o | output | 2 | Per-pair interrupt |
| status_o | output | 20 | Snapshots when enabled, live masked lines when disabled |

## Verification
Two functions can meet in one cycle: the tick that completes a pair's interval (`fire`) and the host's clear of that same pair. The bench lets a pair count to one tick short of its interval. It then drives the final tick and a 0x3B read of that pair on the same edge, and expects the interrupt to stay high with the new snapshot. A related clash is also provoked: an interval completes while the interrupt is already high. There the bench expects the interrupt to stay high with the old snapshot. After the clear it expects a low cycle followed by a rise carrying the newer value.

// File: rtl/sdi_pkg.sv
package sdi_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_PEND   = 2'd2
    } sdi_state_e;

    localparam logic [7:0] OP_READ_ALL = 8'h3B;

endpackage

// File: rtl/sdi_interval_decode.sv
module sdi_interval_decode #(
    parameter int CODE_W = 4,
    parameter int CNT_W  = 6,
    parameter int TICKS_PER_STEP = 4
) (
    input  logic [CODE_W-1:0] code_i,
    output logic              en_o,
    output logic [CNT_W-1:0]  ticks_o
);
    localparam logic [CODE_W-1:0] CODE_OFF  = '0;
    localparam logic [CODE_W-1:0] CODE_FAST = '1;
    localparam logic [CODE_W-1:0] CODE_RSVD = CODE_FAST - 1'b1;

    always_comb begin
        en_o    = 1'b1;
        ticks_o = '0;
        if (code_i == CODE_OFF || code_i == CODE_RSVD) begin
            en_o = 1'b0;
        end else if (code_i == CODE_FAST) begin
            ticks_o = CNT_W'(1);
        end else begin
            ticks_o = CNT_W'(code_i) * CNT_W'(TICKS_PER_STEP);
        end
    end

    // R1: an enabled decode always hands the pair machines a non-zero interval
    always_comb begin
        if (en_o) begin
            p_nonzero_interval_r1: assert (ticks_o != '0);
        end
    end

endmodule

// File: rtl/sdi_pair_fsm.sv
module sdi_pair_fsm
    import sdi_pkg::*;
#(
    parameter int W     = 10,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] ticks_i,
    input  logic [W-1:0]     sig_i,
    input  logic             clr_i,
    output logic             irq_o,
    output logic [W-1:0]     snap_o
);
    sdi_state_e       st_q, st_n;
    logic [W-1:0]     ref_q, ref_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic             irq_n;
    logic [W-1:0]     snap_n;
    logic             changed;
    logic             done;
    logic [CNT_W:0]   cnt_inc;

    assign changed = (sig_i != ref_q);
    assign cnt_inc = {1'b0, cnt_q} + 1'b1;
    assign done    = (cnt_inc >= {1'b0, ticks_i});

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            ref_q  <= '0;
            cnt_q  <= '0;
            irq_o  <= 1'b0;
            snap_o <= '0;
        end else begin
            st_q   <= st_n;
            ref_q  <= ref_n;
            cnt_q  <= cnt_n;
            irq_o  <= irq_n;
            snap_o <= snap_n;
        end
    end

    // next state and outputs
    always_comb begin
        st_n   = st_q;
        ref_n  = ref_q;
        cnt_n  = cnt_q;
        irq_n  = irq_o & ~clr_i;
        snap_n = snap_o;
        if (!en_i) begin
            st_n  = ST_IDLE;
            ref_n = sig_i;
            cnt_n = '0;
            irq_n = 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (changed) begin
                        ref_n = sig_i;
                        cnt_n = '0;
                        st_n  = ST_SETTLE;
                    end
                end
                ST_SETTLE: begin
                    if (changed) begin
                        ref_n = sig_i;
                        cnt_n = '0;
                    end else if (tick_i) begin
                        if (done) begin
                            cnt_n = '0;
                            if (!irq_o) begin
                                irq_n  = 1'b1;
                                snap_n = ref_q;
                                st_n   = ST_IDLE;
                            end else begin
                                st_n = ST_PEND;
                            end
                        end else begin
                            cnt_n = cnt_inc[CNT_W-1:0];
                        end
                    end
                end
                ST_PEND: begin
                    if (changed) begin
                        ref_n = sig_i;
                        cnt_n = '0;
                        st_n  = ST_SETTLE;
                    end else if (!irq_o) begin
                        irq_n  = 1'b1;
                        snap_n = ref_q;
                        st_n   = ST_IDLE;
                    end
                end
                default: st_n = ST_IDLE;
            endcase
        end
    end

    p_off_no_irq_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !irq_o);

    p_snap_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(snap_o) |-> $rose(irq_o));

    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && irq_o) |=> !irq_o);

    p_rise_after_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($past(st_q) != ST_IDLE));

    p_no_tick_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !tick_i && !changed && st_q == ST_SETTLE) |=> $stable(cnt_q));

endmodule

// File: rtl/sig_debounce_irq.sv
module sig_debounce_irq
    import sdi_pkg::*;
#(
    parameter int NUM_PAIRS      = 2,
    parameter int PAIR_W         = 10,
    parameter int CODE_W         = 4,
    parameter int CNT_W          = 6,
    parameter int TICKS_PER_STEP = 4,
    parameter logic [PAIR_W-1:0] FIXED_IN_MASK = 10'b00011_00011,
    localparam int TOT_W = NUM_PAIRS * PAIR_W,
    localparam int SEL_W = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [CODE_W-1:0] interval_code_i,
    input  logic [TOT_W-1:0]  dir_mask_i,
    input  logic [TOT_W-1:0]  sig_i,
    input  logic              rd_strobe_i,
    input  logic [7:0]        rd_opcode_i,
    input  logic [SEL_W-1:0]  rd_pair_i,
    output logic [NUM_PAIRS-1:0] irq_o,
    output logic [TOT_W-1:0]  status_o
);
    logic             en;
    logic [CNT_W-1:0] ticks;
    logic             rd_all;

    assign rd_all = rd_strobe_i && (rd_opcode_i == OP_READ_ALL);

    sdi_interval_decode #(
        .CODE_W         (CODE_W),
        .CNT_W          (CNT_W),
        .TICKS_PER_STEP (TICKS_PER_STEP)
    ) u_decode (
        .code_i  (interval_code_i),
        .en_o    (en),
        .ticks_o (ticks)
    );

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        logic [PAIR_W-1:0] eff;
        logic [PAIR_W-1:0] snap;
        logic              clr;

        assign eff = sig_i[p*PAIR_W +: PAIR_W]
                   & (dir_mask_i[p*PAIR_W +: PAIR_W] | FIXED_IN_MASK);
        assign clr = rd_all && (rd_pair_i == SEL_W'(p));

        sdi_pair_fsm #(
            .W     (PAIR_W),
            .CNT_W (CNT_W)
        ) u_fsm (
            .clk     (clk),
            .rst_n   (rst_n),
            .en_i    (en),
            .tick_i  (tick_i),
            .ticks_i (ticks),
            .sig_i   (eff),
            .clr_i   (clr),
            .irq_o   (irq_o[p]),
            .snap_o  (snap)
        );

        assign status_o[p*PAIR_W +: PAIR_W] = en ? snap : eff;
    end

    // R6: a wrong opcode never clears an interrupt that was set
    p_opcode_filter_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe_i && rd_opcode_i != OP_READ_ALL && en && irq_o[0]) |=> irq_o[0]);

endmodule

// File: tb/sig_debounce_irq_tb_top.sv
module sig_debounce_irq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [3:0]  code = 4'd0;
    logic [19:0] mask = '1;
    logic [19:0] sig = '0;
    logic        rd_stb = 1'b0;
    logic [7:0]  rd_op = 8'h00;
    logic        rd_sel = 1'b0;
    logic [1:0]  irq;
    logic [19:0] status;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    sig_debounce_irq dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .interval_code_i(code),
        .dir_mask_i(mask), .sig_i(sig), .rd_strobe_i(rd_stb),
        .rd_opcode_i(rd_op), .rd_pair_i(rd_sel), .irq_o(irq), .status_o(status)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    task automatic set_p0(input logic [9:0] v);
        @(negedge clk) sig[9:0] = v;
        @(negedge clk);
    endtask

    task automatic rd(input logic sel, input logic [7:0] op);
        @(negedge clk) begin rd_stb = 1'b1; rd_op = op; rd_sel = sel; end
        @(negedge clk) rd_stb = 1'b0;
    endtask

    task automatic t_reset;
        chk("R12 irq", 32'(irq), 0);
        chk("R12 status", 32'(status), 0);
    endtask

    task automatic t_disabled;
        code = 4'd0;
        set_p0(10'h155);
        ticks(10);
        chk("R1 code0 irq", 32'(irq), 0);
        chk("R1 code0 live", 32'(status[9:0]), 32'h155);
        code = 4'd14;
        set_p0(10'h0AA);
        ticks(10);
        chk("R1 code14 irq", 32'(irq), 0);
        chk("R1 code14 live", 32'(status[9:0]), 32'h0AA);
    endtask

    task automatic t_interval;
        code = 4'd2;
        set_p0(10'h155);
        ticks(7);
        chk("R2 code2 early", 32'(irq[0]), 0);
        ticks(1);
        chk("R2 code2 rise", 32'(irq[0]), 1);
        chk("R5 snapshot", 32'(status[9:0]), 32'h155);
        rd(1'b0, 8'h3B);
        chk("R6 clear", 32'(irq[0]), 0);
        code = 4'd13;
        set_p0(10'h0AA);
        ticks(51);
        chk("R2 code13 early", 32'(irq[0]), 0);
        ticks(1);
        chk("R2 code13 rise", 32'(irq[0]), 1);
        rd(1'b0, 8'h3B);
    endtask

    task automatic t_fast;
        code = 4'd15;
        set_p0(10'h3FF);
        chk("R3 before tick", 32'(irq[0]), 0);
        ticks(1);
        chk("R3 one tick", 32'(irq[0]), 1);
        rd(1'b0, 8'h3B);
    endtask

    task automatic t_restart;
        code = 4'd1;
        set_p0(10'h001);
        ticks(3);
        set_p0(10'h002);
        ticks(3);
        chk("R4 restarted", 32'(irq[0]), 0);
        ticks(1);
        chk("R4 rise", 32'(irq[0]), 1);
        chk("R4 value", 32'(status[9:0]), 32'h002);
        rd(1'b0, 8'h3B);
    endtask

    task automatic t_notick;
        set_p0(10'h004);
        repeat (60) @(negedge clk);
        chk("R10 no tick", 32'(irq[0]), 0);
        ticks(4);
        chk("R10 ticks resume", 32'(irq[0]), 1);
        rd(1'b0, 8'h3B);
    endtask

    task automatic t_defer;
        set_p0(10'h008);
        ticks(4);
        chk("R9 first rise", 32'(irq[0]), 1);
        set_p0(10'h010);
        ticks(4);
        chk("R9 held high", 32'(irq[0]), 1);
        chk("R5 snapshot held", 32'(status[9:0]), 32'h008);
        rd(1'b0, 8'h3B);
        chk("R9 cleared", 32'(irq[0]), 0);
        @(negedge clk);
        chk("R9 re-rise", 32'(irq[0]), 1);
        chk("R9 new snapshot", 32'(status[9:0]), 32'h010);
        rd(1'b0, 8'h3B);
    endtask

    task automatic t_read_filter;
        set_p0(10'h020);
        ticks(4);
        rd(1'b0, 8'h3A);
        chk("R6 wrong opcode", 32'(irq[0]), 1);
        rd(1'b1, 8'h3B);
        chk("R6 other pair", 32'(irq[0]), 1);
        rd(1'b0, 8'h3B);
        chk("R6 cleared", 32'(irq[0]), 0);
    endtask

    task automatic t_isolation;
        @(negedge clk) sig[19:10] = 10'h003;
        @(negedge clk);
        ticks(4);
        chk("R7 irq pair1 only", 32'(irq), 32'h2);
        chk("R7 pair0 snapshot", 32'(status[9:0]), 32'h020);
        chk("R7 pair1 snapshot", 32'(status[19:10]), 32'h003);
        rd(1'b1, 8'h3B);
    endtask

    task automatic t_mask;
        mask[9:0] = 10'b00000_00000;
        set_p0(10'h03C);
        ticks(8);
        chk("R8 masked no irq", 32'(irq[0]), 0);
        code = 4'd0;
        @(negedge clk);
        chk("R8 masked reads 0", 32'(status[9:0]), 32'h020);
        mask[9:0] = '1;
        @(negedge clk);
        chk("R8 unmasked live", 32'(status[9:0]), 32'h03C);
        code = 4'd1;
        @(negedge clk);
    endtask

    task automatic t_collision;
        set_p0(10'h040);
        ticks(3);
        @(negedge clk) begin tick = 1'b1; rd_stb = 1'b1; rd_op = 8'h3B; rd_sel = 1'b0; end
        @(negedge clk) begin tick = 1'b0; rd_stb = 1'b0; end
        chk("R11 set wins", 32'(irq[0]), 1);
        chk("R11 snapshot", 32'(status[9:0]), 32'h040);
        rd(1'b0, 8'h3B);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_interval();
        t_fast();
        code = 4'd1;
        t_restart();
        t_notick();
        t_defer();
        t_read_filter();
        t_isolation();
        t_mask();
        t_collision();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule